// File: doc/BRIEF.md
# Memory-to-Memory Word Transfer Sequencer

This block copies a single data word from one memory location to another. It reads the word at a source address and holds it in an internal register. It then writes that register to a destination address. The path is fixed: a read phase of four states (R1 to R4) always runs first, followed by a write phase of four states (W1 to W4). A slow memory can stretch either strobe state by holding `ready` high.

A channel controller starts the block with a one-cycle `start` pulse in idle, with source and destination addresses presented at the same time. To move another word for the same request, the controller holds `start` high during W4 and presents the next pair of addresses. The sequencer then goes straight back to R1. An active-low end-of-process input may be pulled low at any point during a transfer. The word in flight still completes, after which the sequencer stops in idle with `term` set.

Top module: `m2m_xfer_seq`

## Requirements
- R1: While reset is asserted and right after it is released: `mem_rd_n` and `mem_wr_n` are 1, `addr` is 0, `wdata` is 0, `done` and `term` are 0, and the sequencer is idle.
- R2: `start` high at a clock edge in idle captures `src_addr` and `dst_addr` and enters R1. During R1, R2 and R3, `addr` shows the captured source address. `mem_rd_n` is low only in R3.
- R3: R3 repeats while `ready` is sampled high at the clock edge. The first edge with `ready` low moves to R4, where `mem_rd_n` returns to 1 for exactly one cycle.
- R4: The edge that leaves R4 loads `rdata` into the holding register. In W3, `wdata` equals that register. In every other state `wdata` is 0.
- R5: R4 is always followed by W1, and W1 by W2, with no wait. During W1 to W4, `addr` shows the captured destination address. `mem_wr_n` is low only in W3, and W3 repeats while `ready` is sampled high.
- R6: `mem_rd_n` and `mem_wr_n` are never low in the same cycle, and both are 1 in idle.
- R7: `done` is 1 for exactly the one cycle after W4, and 0 otherwise.
- R8: `start` high at the W4 edge, with no end-of-process seen in this word, goes directly to R1 with freshly captured addresses. `start` is ignored in R1 through W3.
- R9: `eop_n` sampled low in any state from R1 to W4 lets the word finish through W4. The sequencer then returns to idle with `term` = 1, even if `start` is high in W4. `term` stays 1 in idle until the next accepted `start` clears it.
- R10: `eop_n` low while idle has no effect: the next transfer ends with `term` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe in idle; continue request in W4 |
| src_addr | input | AW | Source word address |
| dst_addr | input | AW | Destination word address |
| rdata | input | DW | Read data from memory, sampled in R4 |
| ready | input | 1 | Wait request, active high; stretches R3 and W3 |
| eop_n | input | 1 | External end of process, active low |
| addr | output | AW | Memory address bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| wdata | output | DW | Write data, valid in W3 |
| done | output | 1 | One-cycle pulse after each completed word |
| term | output | 1 | Transfer ended by end of process |

## Verification
The hardest cases to reach are those where end-of-process and a continue request meet. Examples are a pulse that arrives in R2 and is gone long before W4 decides whether to repeat, or one that arrives in the very W4 cycle in which `start` asks for another word. The stimulus table places a one-cycle `eop_n` pulse in a chosen state index during a transfer, and in some rows also holds `start` high in W4. The bench can therefore confirm that the remembered event overrides the continue request. Further directed cases pulse `eop_n` in idle, and assert reset in the middle of a stretched read strobe.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_R1   = 4'd1,
      ST_R2   = 4'd2,
      ST_R3   = 4'd3,
      ST_R4   = 4'd4,
      ST_W1   = 4'd5,
      ST_W2   = 4'd6,
      ST_W3   = 4'd7,
      ST_W4   = 4'd8
   } m2m_state_e;

   function automatic logic is_read_phase(m2m_state_e s);
      return (s == ST_R1) || (s == ST_R2) || (s == ST_R3) || (s == ST_R4);
   endfunction

   function automatic logic is_write_phase(m2m_state_e s);
      return (s == ST_W1) || (s == ST_W2) || (s == ST_W3) || (s == ST_W4);
   endfunction

endpackage

// File: rtl/m2m_fsm.sv
module m2m_fsm
   import m2m_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       ready,
   input  logic       eop_n,
   output m2m_state_e state_o,
   output logic       launch_o,
   output logic       done_o,
   output logic       term_o
);

   m2m_state_e state_q, state_d;
   logic       eop_seen_q;
   logic       stop_now;
   logic       done_q;
   logic       term_q;

   // end-of-process seen anywhere in this word, including the current cycle
   assign stop_now = eop_seen_q || !eop_n;

   assign launch_o = ((state_q == ST_IDLE) && start) ||
                     ((state_q == ST_W4) && start && !stop_now);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_R1;
         ST_R1:   state_d = ST_R2;
         ST_R2:   state_d = ST_R3;
         ST_R3:   state_d = ready ? ST_R3 : ST_R4;
         ST_R4:   state_d = ST_W1;
         ST_W1:   state_d = ST_W2;
         ST_W2:   state_d = ST_W3;
         ST_W3:   state_d = ready ? ST_W3 : ST_W4;
         ST_W4:   state_d = (start && !stop_now) ? ST_R1 : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         eop_seen_q <= 1'b0;
         done_q     <= 1'b0;
         term_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_W4);
         if (state_q == ST_IDLE)
            eop_seen_q <= 1'b0;
         else if (!eop_n)
            eop_seen_q <= 1'b1;
         if (state_q == ST_W4)
            term_q <= stop_now;
         else if ((state_q == ST_IDLE) && start)
            term_q <= 1'b0;
      end
   end

   assign state_o = state_q;
   assign done_o  = done_q;
   assign term_o  = term_q;

   // R9: the terminate flag is only ever visible while idle
   p_term_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      term_q |-> (state_q == ST_IDLE));

   // R7: done lasts a single cycle
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5: W1 is only ever entered from R4
   p_w1_after_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_W1) |-> ($past(state_q) == ST_R4));

   // R8: mid-transfer states never jump back to R1
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_R1, ST_R2, ST_R3, ST_R4, ST_W1, ST_W2, ST_W3})
      |=> (state_q != ST_R1));

endmodule

// File: rtl/m2m_datapath.sv
module m2m_datapath
   import m2m_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter bit HOLD_WDATA = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  m2m_state_e    state,
   input  logic          launch,
   input  logic [AW-1:0] src_addr,
   input  logic [AW-1:0] dst_addr,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata
);

   logic [AW-1:0] src_q;
   logic [AW-1:0] dst_q;
   logic [DW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         hold_q <= '0;
      end else begin
         if (launch) begin
            src_q <= src_addr;
            dst_q <= dst_addr;
         end
         if (state == ST_R4)
            hold_q <= rdata;
      end
   end

   always_comb begin
      if (is_read_phase(state))
         addr = src_q;
      else if (is_write_phase(state))
         addr = dst_q;
      else
         addr = '0;
   end

   generate
      if (HOLD_WDATA) begin : g_wdata_hold
         assign wdata = hold_q;
      end else begin : g_wdata_gated
         assign wdata = (state == ST_W3) ? hold_q : '0;
      end
   endgenerate

   // R4: the holding register takes the word present during R4
   p_hold_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_R4) |=> (hold_q == $past(rdata)));

   // R2: the source address stays put through the read phase
   p_src_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state inside {ST_R2, ST_R3, ST_R4}) && (addr != '0)) |-> $stable(src_q));

endmodule

// File: rtl/m2m_strobe.sv
module m2m_strobe
   import m2m_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  m2m_state_e state,
   input  logic       ready,
   output logic       mem_rd_n,
   output logic       mem_wr_n
);

   assign mem_rd_n = (state != ST_R3);
   assign mem_wr_n = (state != ST_W3);

   // R6: the two strobes are mutually exclusive
   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_rd_n && !mem_wr_n));

   // R3: read strobe held while the memory waits
   p_rd_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n && ready) |=> !mem_rd_n);

   // R3: read strobe released once the memory is ready
   p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n && !ready) |=> mem_rd_n);

   // R5: write strobe held while the memory waits, then released
   p_wr_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n && ready) |=> !mem_wr_n);

   p_wr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n && !ready) |=> mem_wr_n);

endmodule

// File: rtl/m2m_xfer_seq.sv
module m2m_xfer_seq
   import m2m_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter bit HOLD_WDATA = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] src_addr,
   input  logic [AW-1:0] dst_addr,
   input  logic [DW-1:0] rdata,
   input  logic          ready,
   input  logic          eop_n,
   output logic [AW-1:0] addr,
   output logic          mem_rd_n,
   output logic          mem_wr_n,
   output logic [DW-1:0] wdata,
   output logic          done,
   output logic          term
);

   generate
      if (AW < 1 || AW > 64) begin : g_bad_aw
         $error("m2m_xfer_seq: AW must lie in 1..64");
      end
      if (DW < 1 || DW > 256) begin : g_bad_dw
         $error("m2m_xfer_seq: DW must lie in 1..256");
      end
   endgenerate

   m2m_state_e state;
   logic       launch;

   m2m_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ready    (ready),
      .eop_n    (eop_n),
      .state_o  (state),
      .launch_o (launch),
      .done_o   (done),
      .term_o   (term)
   );

   m2m_datapath #(
      .AW         (AW),
      .DW         (DW),
      .HOLD_WDATA (HOLD_WDATA)
   ) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .launch   (launch),
      .src_addr (src_addr),
      .dst_addr (dst_addr),
      .rdata    (rdata),
      .addr     (addr),
      .wdata    (wdata)
   );

   m2m_strobe u_stb (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .ready    (ready),
      .mem_rd_n (mem_rd_n),
      .mem_wr_n (mem_wr_n)
   );

   // R7: done follows the write strobe's release
   p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mem_wr_n && mem_rd_n || (state == ST_R1));

   // R6: idle keeps both strobes inactive
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (mem_rd_n && mem_wr_n && addr == '0));

endmodule

// File: tb/m2m_xfer_seq_tb.sv
module m2m_xfer_seq_tb;

   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] src_addr = '0;
   logic [AW-1:0] dst_addr = '0;
   logic [DW-1:0] rdata = '0;
   logic          ready = 1'b0;
   logic          eop_n = 1'b1;
   logic [AW-1:0] addr;
   logic          mem_rd_n;
   logic          mem_wr_n;
   logic [DW-1:0] wdata;
   logic          done;
   logic          term;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #5 clk = ~clk;

   m2m_xfer_seq #(.AW(AW), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
      .dst_addr(dst_addr), .rdata(rdata), .ready(ready), .eop_n(eop_n),
      .addr(addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .wdata(wdata),
      .done(done), .term(term)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, act %0d cycles exp < 20000", cyc);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: act %h exp %h", req, $time, act, exp);
      end
   endtask

   typedef struct packed {
      logic [15:0] s;
      logic [15:0] d;
      logic [7:0]  dat;
      logic [3:0]  rw;
      logic [3:0]  ww;
      logic        cont;
      logic [3:0]  eop;
   } vec_t;

   // eop: 0 = none, 1..8 = state R1,R2,R3,R4,W1,W2,W3,W4 in which eop_n pulses low
   localparam vec_t VECS [8] = '{
      '{16'h0100, 16'h0200, 8'hA5, 4'd0, 4'd0, 1'b0, 4'd0},
      '{16'h0104, 16'h0208, 8'h3C, 4'd2, 4'd0, 1'b0, 4'd0},
      '{16'h010C, 16'h021C, 8'hF0, 4'd0, 4'd3, 1'b1, 4'd0},
      '{16'h0110, 16'h0220, 8'h0F, 4'd1, 4'd1, 1'b0, 4'd0},
      '{16'h0120, 16'h0240, 8'h55, 4'd0, 4'd0, 1'b0, 4'd2},
      '{16'h0130, 16'h0250, 8'h66, 4'd3, 4'd2, 1'b0, 4'd3},
      '{16'h0140, 16'h0260, 8'h77, 4'd0, 4'd0, 1'b1, 4'd8},
      '{16'h0150, 16'h0270, 8'h88, 4'd0, 4'd0, 1'b0, 4'd0}
   };

   task automatic xfer(input vec_t v, input logic [15:0] ns, input logic [15:0] nd, input bit from_idle);
      bit ex_term;
      ex_term = (v.eop != 0);
      if (from_idle) begin
         src_addr = v.s; dst_addr = v.d; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(term == 1'b0, "R9 term cleared by start", term, 0);
      end
      // R1
      rdata = v.dat;
      eop_n = (v.eop == 1) ? 1'b0 : 1'b1;
      chk(addr == v.s && mem_rd_n && mem_wr_n, "R2 R1 state", {addr, mem_rd_n, mem_wr_n}, {v.s, 2'b11});
      @(negedge clk);
      // R2, start pulsed here must be ignored (R8)
      eop_n = (v.eop == 2) ? 1'b0 : 1'b1;
      start = 1'b1;
      chk(addr == v.s && mem_rd_n, "R2 R2 state", {addr, mem_rd_n}, {v.s, 1'b1});
      @(negedge clk);
      start = 1'b0;
      // R3 stretch
      for (int i = 0; i <= int'(v.rw); i++) begin
         chk(!mem_rd_n && mem_wr_n && addr == v.s, "R3 read strobe low", {addr, mem_rd_n}, {v.s, 1'b0});
         ready = (i < int'(v.rw));
         eop_n = (v.eop == 3 && i == 0) ? 1'b0 : 1'b1;
         @(negedge clk);
      end
      // R4
      ready = 1'b0;
      eop_n = (v.eop == 4) ? 1'b0 : 1'b1;
      chk(mem_rd_n && mem_wr_n && addr == v.s, "R3 R4 strobe high", {mem_rd_n, mem_wr_n}, 2'b11);
      @(negedge clk);
      rdata = ~v.dat;
      // W1
      eop_n = (v.eop == 5) ? 1'b0 : 1'b1;
      chk(addr == v.d && mem_rd_n && mem_wr_n, "R5 W1 destination", addr, v.d);
      chk(wdata == 0, "R4 wdata zero in W1", wdata, 0);
      @(negedge clk);
      // W2
      eop_n = (v.eop == 6) ? 1'b0 : 1'b1;
      chk(addr == v.d && mem_wr_n, "R5 W2", {addr, mem_wr_n}, {v.d, 1'b1});
      @(negedge clk);
      // W3 stretch
      for (int i = 0; i <= int'(v.ww); i++) begin
         chk(!mem_wr_n && mem_rd_n && addr == v.d, "R5 write strobe low", {addr, mem_wr_n}, {v.d, 1'b0});
         chk(wdata == v.dat, "R4 wdata from holding reg", wdata, v.dat);
         ready = (i < int'(v.ww));
         eop_n = (v.eop == 7 && i == 0) ? 1'b0 : 1'b1;
         @(negedge clk);
      end
      // W4
      ready = 1'b0;
      eop_n = (v.eop == 8) ? 1'b0 : 1'b1;
      chk(mem_wr_n && done == 1'b0 && wdata == 0, "R7 W4 no done yet", {mem_wr_n, done}, 2'b10);
      if (v.cont) begin
         start = 1'b1; src_addr = ns; dst_addr = nd;
      end
      @(negedge clk);
      start = 1'b0;
      eop_n = 1'b1;
      chk(done == 1'b1, "R7 done after W4", done, 1);
      chk(term == ex_term, "R9 term after word", term, ex_term);
      if (!v.cont || ex_term) begin
         chk(mem_rd_n && mem_wr_n && addr == 0, "R6 idle after word", {addr, mem_rd_n, mem_wr_n}, 18'h3);
         @(negedge clk);
         chk(done == 1'b0 && mem_rd_n, "R7 done single cycle", done, 0);
      end
   endtask

   initial begin
      bit from_idle;
      // R1: reset state
      #2;
      chk(mem_rd_n && mem_wr_n && addr == 0 && wdata == 0 && !done && !term,
          "R1 in reset", {addr, mem_rd_n, mem_wr_n, done, term}, 20'hC);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_rd_n && mem_wr_n && addr == 0 && !done && !term,
          "R1 after reset", {addr, mem_rd_n, mem_wr_n, done, term}, 20'hC);

      from_idle = 1'b1;
      for (int i = 0; i < 8; i++) begin
         vec_t nx;
         nx = (i < 7) ? VECS[i+1] : VECS[0];
         xfer(VECS[i], nx.s, nx.d, from_idle);
         from_idle = !(VECS[i].cont && VECS[i].eop == 0);
      end

      // R10: eop_n low in idle must not set term on the next word
      eop_n = 1'b0;
      @(negedge clk);
      eop_n = 1'b1;
      @(negedge clk);
      xfer('{16'h0300, 16'h0400, 8'h5A, 4'd0, 4'd0, 1'b0, 4'd0}, 16'h0, 16'h0, 1'b1);
      chk(term == 1'b0, "R10 idle eop ignored", term, 0);

      // R9: term holds in idle for several cycles
      xfer('{16'h0310, 16'h0410, 8'hC3, 4'd1, 4'd0, 1'b0, 4'd5}, 16'h0, 16'h0, 1'b1);
      repeat (3) @(negedge clk);
      chk(term == 1'b1, "R9 term held in idle", term, 1);

      // R1: reset in the middle of a stretched read strobe
      src_addr = 16'h0500; dst_addr = 16'h0600; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mem_rd_n, "R3 stretched before reset", mem_rd_n, 0);
      rst_n = 1'b0;
      #1;
      chk(mem_rd_n && mem_wr_n && addr == 0 && !term, "R1 reset mid transfer",
          {addr, mem_rd_n, mem_wr_n, term}, 19'h6);
      @(negedge clk);
      rst_n = 1'b1;
      ready = 1'b0;
      @(negedge clk);
      chk(mem_rd_n && addr == 0, "R1 idle after mid reset", {addr, mem_rd_n}, 17'h1);

      finish_run();
   end

endmodule